// File: doc/BRIEF.md
# Wrapping Serial Read Address Generator

This block keeps the read pointer for a serial memory that streams stored bytes out one bit at a time. A command decoder hands it a starting page, a starting byte and a read type, then pulses a load strobe. From then on every shift pulse, one per output clock, moves the bit pointer down from the most significant bit. When the last bit of a byte has gone out, the next shift moves to the following byte. Pages hold 264 bytes, which is not a power of two, so every byte step compares against the last byte of the page instead of relying on a counter overflow.

Each read type wraps in its own way. A streaming read of the whole array runs into the next page and, after the last page, back to page 0. A single-page read stays inside its page. A buffer read stays inside its 264-byte buffer. One output clock before a new byte is needed, the block raises a fetch strobe. While the strobe is high, a look-ahead address port names the byte that will be needed, so the memory model can have it ready with no stall. Taking chip select high clears the pointer.

Top module: `rd_addr_gen`

## Requirements
- R1: While reset is active or `cs_n` is high, and in the cycle after either, the outputs read `page_o`=0, `byte_o`=0, `bit_o`=7, `fetch_o`=0 and `active_o`=0.
- R2: A `load_i` pulse with `cs_n` low sets `active_o`=1 and `bit_o`=7. It loads `page_i` and `byte_i` into `page_o` and `byte_o` at the next edge. A load has priority over a shift, and it restarts a read already in progress.
- R3: With `cs_n` low and `load_i` low, the pointer holds in any cycle without `shift_i`. A shift while `active_o`=0 changes nothing.
- R4: With `active_o`=1, each `shift_i` lowers `bit_o` by one. A shift at `bit_o`=0 sets `bit_o` to 7 and moves the byte pointer one step.
- R5: `mode_i`=2'b00 selects a streaming array read. In this mode a step from byte 263 goes to byte 0 of the next page on the same edge.
- R6: In a streaming array read, a step from byte 263 of page 1023 goes to byte 0 of page 0.
- R7: `mode_i`=2'b01 and 2'b11 select a single-page read. In this mode a step from byte 263 goes to byte 0 of the same page.
- R8: `mode_i`=2'b10 selects a buffer read. A load in this mode forces `page_o` to 0, and a step from byte 263 goes to byte 0 with `page_o` still 0.
- R9: A starting byte of 264 to 511 loads as 263, so the first byte step wraps as the read type demands.
- R10: `fetch_o` is high for exactly one cycle, in the cycle right after a shift that took `bit_o` from 1 to 0, and at no other time.
- R11: `nxt_page_o` and `nxt_byte_o` always give the address that the next byte step will move to, under the current read type.
- R12: Raising `cs_n` in the middle of a read ends it and clears the pointer as in R1. Shifts after that have no effect until a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low; high clears the pointer |
| load_i | input | 1 | Start strobe from the command decoder |
| mode_i | input | 2 | Read type: 00 array, 01/11 single page, 10 buffer |
| page_i | input | 10 | Starting page |
| byte_i | input | 9 | Starting byte within page or buffer |
| shift_i | input | 1 | One pulse per output bit |
| page_o | output | 10 | Current page |
| byte_o | output | 9 | Current byte |
| bit_o | output | 3 | Current bit index, 7 down to 0 |
| fetch_o | output | 1 | Byte-fetch strobe, one cycle before the next byte is needed |
| nxt_page_o | output | 10 | Page of the byte that follows |
| nxt_byte_o | output | 9 | Byte that follows |
| active_o | output | 1 | A read is in progress |

## Verification
Each read type is started just short of the last byte, so that the same shift run shows three different results: a carry into the next page, a return to the start of the same page, and a return to the start of the buffer. A start on byte 263 of the last page separates the wrap to page 0 from a plain page increment. A start byte above the page size shows whether the clamp is applied. Shift runs with idle gaps separate holding from stepping and confirm that the fetch strobe stays a single pulse. Raising chip select mid-read, followed by further shifts, and a fresh load in the middle of a read confirm that clearing and restarting take precedence over stepping.

// File: rtl/rdag_pkg.sv
package rdag_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY    = 2'b00,
    RD_PAGE     = 2'b01,
    RD_BUF      = 2'b10,
    RD_PAGE_ALT = 2'b11
  } rd_mode_e;
endpackage

// File: rtl/rdag_rst_sync.sv
module rdag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rdag_bit_ctr.sv
module rdag_bit_ctr #(
  parameter int BITS_PER_BYTE = 8,
  localparam int IW = $clog2(BITS_PER_BYTE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          adv,
  output logic [IW-1:0] bit_q,
  output logic          byte_step,
  output logic          fetch_q
);
  localparam logic [IW-1:0] TOP = IW'(BITS_PER_BYTE - 1);

  logic [IW-1:0] bit_d;
  logic          bit_en;
  logic          fetch_d;
  logic          plain_adv;

  assign plain_adv = adv && !load && !clr;
  assign byte_step = plain_adv && (bit_q == '0);

  always_comb begin
    bit_en  = clr || load || plain_adv;
    bit_d   = bit_q;
    fetch_d = 1'b0;
    if (clr || load) begin
      bit_d = TOP;
    end else if (plain_adv) begin
      bit_d   = (bit_q == '0) ? TOP : bit_q - IW'(1);
      fetch_d = (bit_q == IW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= TOP;
      fetch_q <= 1'b0;
    end else begin
      if (bit_en) bit_q <= bit_d;
      fetch_q <= fetch_d;
    end
  end
endmodule

// File: rtl/rdag_byte_ctr.sv
module rdag_byte_ctr #(
  parameter int PAGE_BYTES = 264,
  localparam int BW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] start_byte,
  input  logic          step,
  output logic [BW-1:0] byte_q,
  output logic [BW-1:0] nxt_byte,
  output logic          at_last,
  output logic          wrap
);
  localparam logic [BW-1:0] LAST = BW'(PAGE_BYTES - 1);
  localparam bit POW2 = (PAGE_BYTES == (1 << BW));

  logic [BW-1:0] byte_d;
  logic [BW-1:0] clamped;
  logic          byte_en;

  assign at_last = (byte_q == LAST);
  assign wrap    = step && at_last;

  generate
    if (POW2) begin : g_pow2
      assign nxt_byte = byte_q + BW'(1);
      assign clamped  = start_byte;
    end else begin : g_odd
      assign nxt_byte = at_last ? '0 : byte_q + BW'(1);
      assign clamped  = (start_byte > LAST) ? LAST : start_byte;
    end
  endgenerate

  always_comb begin
    byte_en = clr || load || step;
    byte_d  = byte_q;
    if (clr)       byte_d = '0;
    else if (load) byte_d = clamped;
    else if (step) byte_d = nxt_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= byte_d;
  end
endmodule

// File: rtl/rdag_page_ctr.sv
module rdag_page_ctr #(
  parameter int NUM_PAGES = 1024,
  localparam int PW = $clog2(NUM_PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          zero_on_load,
  input  logic [PW-1:0] start_page,
  input  logic          carry,
  output logic [PW-1:0] page_q,
  output logic [PW-1:0] page_inc
);
  localparam logic [PW-1:0] LAST = PW'(NUM_PAGES - 1);
  localparam bit POW2 = (NUM_PAGES == (1 << PW));

  logic [PW-1:0] page_d;
  logic          page_en;

  generate
    if (POW2) begin : g_pow2
      assign page_inc = page_q + PW'(1);
    end else begin : g_odd
      assign page_inc = (page_q == LAST) ? '0 : page_q + PW'(1);
    end
  endgenerate

  always_comb begin
    page_en = clr || load || carry;
    page_d  = page_q;
    if (clr)        page_d = '0;
    else if (load)  page_d = zero_on_load ? '0 : start_page;
    else if (carry) page_d = page_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end
endmodule

// File: rtl/rd_addr_gen.sv
module rd_addr_gen #(
  parameter int PAGE_BYTES    = 264,
  parameter int NUM_PAGES     = 1024,
  parameter int BITS_PER_BYTE = 8,
  localparam int BW = $clog2(PAGE_BYTES),
  localparam int PW = $clog2(NUM_PAGES),
  localparam int IW = $clog2(BITS_PER_BYTE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          load_i,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] page_i,
  input  logic [BW-1:0] byte_i,
  input  logic          shift_i,
  output logic [PW-1:0] page_o,
  output logic [BW-1:0] byte_o,
  output logic [IW-1:0] bit_o,
  output logic          fetch_o,
  output logic [PW-1:0] nxt_page_o,
  output logic [BW-1:0] nxt_byte_o,
  output logic          active_o
);
  import rdag_pkg::*;

  logic          rst_n_int;
  rd_mode_e      mode_q;
  rd_mode_e      mode_d;
  logic          active_q;
  logic          active_d;
  logic          ctl_en;
  logic          clr;
  logic          load;
  logic          adv;
  logic          byte_step;
  logic          byte_wrap;
  logic          byte_at_last;
  logic          carry;
  logic [PW-1:0] page_inc;

  assign clr   = cs_n;
  assign load  = load_i && !cs_n;
  assign adv   = shift_i && active_q;
  assign carry = byte_wrap && (mode_q == RD_ARRAY);

  rdag_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    ctl_en   = clr || load;
    mode_d   = mode_q;
    active_d = active_q;
    if (clr) begin
      mode_d   = RD_ARRAY;
      active_d = 1'b0;
    end else if (load) begin
      mode_d   = rd_mode_e'(mode_i);
      active_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mode_q   <= RD_ARRAY;
      active_q <= 1'b0;
    end else if (ctl_en) begin
      mode_q   <= mode_d;
      active_q <= active_d;
    end
  end

  rdag_bit_ctr #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_bit (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (clr),
    .load      (load),
    .adv       (adv),
    .bit_q     (bit_o),
    .byte_step (byte_step),
    .fetch_q   (fetch_o)
  );

  rdag_byte_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_byte (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr        (clr),
    .load       (load),
    .start_byte (byte_i),
    .step       (byte_step),
    .byte_q     (byte_o),
    .nxt_byte   (nxt_byte_o),
    .at_last    (byte_at_last),
    .wrap       (byte_wrap)
  );

  rdag_page_ctr #(.NUM_PAGES(NUM_PAGES)) u_page (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .clr          (clr),
    .load         (load),
    .zero_on_load (mode_i == RD_BUF),
    .start_page   (page_i),
    .carry        (carry),
    .page_q       (page_o),
    .page_inc     (page_inc)
  );

  assign nxt_page_o = (byte_at_last && (mode_q == RD_ARRAY)) ? page_inc : page_o;
  assign active_o   = active_q;
endmodule

// File: rtl/rdag_checker.sv
module rdag_checker #(
  parameter int PAGE_BYTES    = 264,
  parameter int NUM_PAGES     = 1024,
  parameter int BITS_PER_BYTE = 8,
  localparam int BW = $clog2(PAGE_BYTES),
  localparam int PW = $clog2(NUM_PAGES),
  localparam int IW = $clog2(BITS_PER_BYTE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          load_i,
  input logic          shift_i,
  input logic [1:0]    mode_q,
  input logic          active,
  input logic [PW-1:0] page,
  input logic [BW-1:0] byt,
  input logic [IW-1:0] bitn,
  input logic          fetch,
  input logic [PW-1:0] nxt_page,
  input logic [BW-1:0] nxt_byte
);
  localparam logic [IW-1:0] TOP  = IW'(BITS_PER_BYTE - 1);
  localparam logic [BW-1:0] LAST = BW'(PAGE_BYTES - 1);

  // R1
  clear_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!active && bitn == TOP && byt == '0 && page == '0 && !fetch));

  // R3
  hold_without_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !load_i && !shift_i) |=> ($stable(bitn) && $stable(byt) && $stable(page)));

  // R4
  bit_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !load_i && shift_i && active && bitn != '0) |=> (bitn == IW'($past(bitn) - 1'b1)));

  // R11
  lookahead_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !load_i && shift_i && active && bitn == '0)
      |=> (bitn == TOP && byt == $past(nxt_byte) && page == $past(nxt_page)));

  // R10
  fetch_on_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (bitn == '0 && active));

  // R10
  fetch_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> !fetch);

  // R9
  byte_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byt <= LAST);

  // R8
  buffer_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_q == 2'b10) |-> (page == '0));
endmodule

bind rd_addr_gen rdag_checker #(
  .PAGE_BYTES    (PAGE_BYTES),
  .NUM_PAGES     (NUM_PAGES),
  .BITS_PER_BYTE (BITS_PER_BYTE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .load_i   (load_i),
  .shift_i  (shift_i),
  .mode_q   (mode_q),
  .active   (active_q),
  .page     (page_o),
  .byt      (byte_o),
  .bitn     (bit_o),
  .fetch    (fetch_o),
  .nxt_page (nxt_page_o),
  .nxt_byte (nxt_byte_o)
);

// File: tb/sim_rd_addr_gen.sv
module sim_rd_addr_gen;
  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic       load_i;
  logic [1:0] mode_i;
  logic [9:0] page_i;
  logic [8:0] byte_i;
  logic       shift_i;
  logic [9:0] page_o;
  logic [8:0] byte_o;
  logic [2:0] bit_o;
  logic       fetch_o;
  logic [9:0] nxt_page_o;
  logic [8:0] nxt_byte_o;
  logic       active_o;

  rd_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .load_i(load_i), .mode_i(mode_i),
    .page_i(page_i), .byte_i(byte_i), .shift_i(shift_i), .page_o(page_o),
    .byte_o(byte_o), .bit_o(bit_o), .fetch_o(fetch_o), .nxt_page_o(nxt_page_o),
    .nxt_byte_o(nxt_byte_o), .active_o(active_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int    pg;
    int    by;
    int    bi;
    bit    fe;
    bit    ac;
    int    np;
    int    nb;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int  m_pg, m_by, m_bi, m_md;
  bit  m_fe, m_ac;

  function automatic int nb_of(int b);
    return (b == 263) ? 0 : b + 1;
  endfunction

  function automatic int np_of(int p, int b, int md);
    if (md == 0 && b == 263) return (p == 1023) ? 0 : p + 1;
    return p;
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (int'(page_o) != e.pg || int'(byte_o) != e.by || int'(bit_o) != e.bi ||
        fetch_o != e.fe || active_o != e.ac ||
        int'(nxt_page_o) != e.np || int'(nxt_byte_o) != e.nb) begin
      errors++;
      $display("FAIL %s: got pg=%0d by=%0d bit=%0d fe=%0b ac=%0b np=%0d nb=%0d exp pg=%0d by=%0d bit=%0d fe=%0b ac=%0b np=%0d nb=%0d",
               e.tag, page_o, byte_o, bit_o, fetch_o, active_o, nxt_page_o, nxt_byte_o,
               e.pg, e.by, e.bi, e.fe, e.ac, e.np, e.nb);
    end
  endtask

  task automatic push_model(input string tag);
    exp_t e;
    e.pg = m_pg; e.by = m_by; e.bi = m_bi; e.fe = m_fe; e.ac = m_ac;
    e.np = np_of(m_pg, m_by, m_md); e.nb = nb_of(m_by); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input bit cs, input bit ld, input int md, input int pg,
                       input int by, input bit sh, input string tag);
    @(negedge clk);
    cs_n = cs; load_i = ld; mode_i = md[1:0]; page_i = pg[9:0];
    byte_i = by[8:0]; shift_i = sh;
    if (cs) begin
      m_pg = 0; m_by = 0; m_bi = 7; m_fe = 0; m_ac = 0; m_md = 0;
    end else if (ld) begin
      m_ac = 1; m_md = md; m_pg = (md == 2) ? 0 : pg;
      m_by = (by > 263) ? 263 : by; m_bi = 7; m_fe = 0;
    end else begin
      m_fe = m_ac && sh && (m_bi == 1);
      if (m_ac && sh) begin
        if (m_bi == 0) begin
          m_bi = 7;
          m_pg = np_of(m_pg, m_by, m_md);
          m_by = nb_of(m_by);
        end else begin
          m_bi = m_bi - 1;
        end
      end
    end
    push_model(tag);
  endtask

  task automatic shifts(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic start(input int md, input int pg, input int by, input string tag);
    drive(0, 1, md, pg, by, 0, tag);
  endtask

  // monitor: pops one expected item after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    exp_t r;
    cs_n = 1; load_i = 0; mode_i = 0; page_i = 0; byte_i = 0; shift_i = 0;
    m_pg = 0; m_by = 0; m_bi = 7; m_fe = 0; m_ac = 0; m_md = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset held
    r.pg = 0; r.by = 0; r.bi = 7; r.fe = 0; r.ac = 0; r.np = 0; r.nb = 1; r.tag = "R1 reset";
    compare(r);
    rst_n = 1;
    repeat (4) drive(1, 0, 0, 0, 0, 0, "R1 idle");
    // R3: shifts before any load are ignored
    repeat (3) drive(0, 0, 0, 0, 0, 1, "R3 inactive shift");
    // R2 R4 R10 R11: array read from page 5 byte 10
    start(0, 5, 10, "R2 load array");
    shifts(17, "R4 R10 R11 walk");
    // R3: idle gaps between shifts
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 0, 0, i[0], "R3 gap");
    // R5: cross page boundary
    start(0, 5, 262, "R2 load near end");
    shifts(24, "R5 next page");
    // R6: last page wraps to page 0
    start(0, 1023, 263, "R2 load last");
    shifts(16, "R6 array wrap");
    // R7: single page read, both encodings
    start(1, 7, 262, "R2 load page");
    shifts(24, "R7 same page");
    start(3, 400, 263, "R2 load page alt");
    shifts(12, "R7 same page alt");
    // R8: buffer read forces page 0
    start(2, 99, 263, "R8 buffer load");
    shifts(16, "R8 buffer wrap");
    // R9: clamp start byte
    start(0, 1023, 300, "R9 clamp");
    shifts(9, "R9 clamp wrap");
    start(1, 3, 511, "R9 clamp max");
    shifts(9, "R9 clamp page");
    // R2: restart mid-read, load wins over shift
    start(0, 20, 100, "R2 load");
    shifts(5, "R4 walk");
    drive(0, 1, 1, 21, 50, 1, "R2 restart");
    shifts(3, "R4 after restart");
    // R12: deselect mid-read, then shifts ignored
    drive(1, 0, 0, 0, 0, 1, "R12 deselect");
    repeat (4) drive(0, 0, 0, 0, 0, 1, "R12 shift ignored");
    drive(0, 0, 0, 0, 0, 0, "R12 idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule